// File: doc/BRIEF.md
# Pixel Bit-Depth Reducer with Spatial Dither

This block narrows a stream of 12-bit-per-component pixels (RGB or YCbCr) to 6, 8 or 10 significant bits per component. The result stays left-aligned in a 12-bit word with the dropped low bits forced to zero. It can cut the low bits plainly, or it can first add pseudo-random noise from one 28-bit linear-feedback shift register per channel. Adding noise spreads the quantisation error across the picture, so smooth gradients do not turn into visible bands.

The stream carries a valid strobe, a start-of-frame marker and an end-of-line marker. All three reach the output one clock later, aligned with the reduced pixel. The noise source has several options. Each channel can use its own feedback tap. A high-pass variant uses the difference between successive noise slices. The registers can be reseeded on every frame from a wrapping frame counter. All options are static configuration inputs.

Top module: `pix_depth_reducer`

## Requirements
- R1: `cfg_depth` picks how many bits survive: code 0 keeps 6, code 1 keeps 8, code 2 keeps 10, code 3 keeps all 12. Whenever truncation or dither applies, the dropped low bits of every output component are zero.
- R2: With dither off and truncation effective, each component equals its input with the dropped low bits cleared.
- R3: With dither off and truncation off, each component passes through unchanged.
- R4: With `cfg_ycc422` set, truncation is effective only for depth codes 1 and 2. For codes 0 and 3 a set `cfg_trunc_en` is ignored and the pixel passes unchanged when dither is off.
- R5: Each noise register shifts left by one. Its new bit 0 is bit 27 XOR bit (k-1). With `cfg_chan_taps` clear, k is 3 for all three channels.
- R6: With `cfg_chan_taps` set, k is 3 for R, 9 for G and 13 for B.
- R7: During reset each register loads its own seed (`cfg_seed_r/g/b`). With `cfg_frame_reseed` clear it is never reloaded, and start-of-frame has no effect on it.
- R8: With `cfg_frame_reseed` set, a valid start-of-frame pixel uses a reloaded state instead of the current one. The reloaded state is the seed XOR the 4-bit frame counter (counter in bits 3:0). The counter resets to 0 and then steps. It returns to 0 after 15 for depth codes 0 and 1, and after 3 for codes 2 and 3.
- R9: With dither on, the noise is the register's low d bits, where d is the number of dropped bits. The noise is added to the input, the sum is clamped to 0..4095, and then the low d bits are cleared.
- R10: With `cfg_highpass` set, the noise is (slice - previous slice) shifted right arithmetically by one, which rounds toward minus infinity. The previous slice is 0 after reset and on a reloading pixel.
- R11: Every register advances exactly once per valid pixel, whatever the dither and truncation settings. It holds on cycles without valid.
- R12: Outputs appear one cycle after the input. `out_valid`, `out_sof` and `out_eol` are the registered valid, valid-and-sof and valid-and-eol. Pixel outputs hold on cycles without valid, and all outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads seeds |
| cfg_trunc_en | input | 1 | Truncation enable |
| cfg_dither_en | input | 1 | Spatial dither enable |
| cfg_depth | input | 2 | Target depth code (0:6, 1:8, 2:10, 3:12 bits) |
| cfg_ycc422 | input | 1 | 4:2:2 input; restricts truncation codes |
| cfg_chan_taps | input | 1 | Distinct feedback tap per channel |
| cfg_frame_reseed | input | 1 | Reload noise registers at each frame start |
| cfg_highpass | input | 1 | High-pass noise shaping |
| cfg_seed_r | input | 28 | Seed of the R noise register |
| cfg_seed_g | input | 28 | Seed of the G noise register |
| cfg_seed_b | input | 28 | Seed of the B noise register |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | Start-of-frame marker |
| in_eol | input | 1 | End-of-line marker |
| in_r | input | 12 | R / Cr component |
| in_g | input | 12 | G / Y component |
| in_b | input | 12 | B / Cb component |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Delayed start-of-frame |
| out_eol | output | 1 | Delayed end-of-line |
| out_r | output | 12 | Reduced R / Cr, left-aligned |
| out_g | output | 12 | Reduced G / Y, left-aligned |
| out_b | output | 12 | Reduced B / Cb, left-aligned |

## Verification
The assertions on noise-register stepping and on keeping the register nonzero assume two things. The seeds are nonzero, and a seed XORed with any frame-counter value is still nonzero. The stimulus uses seeds with many set bits in their upper bits to meet this. The frame-counter wrap check assumes the depth code does not change while the counter sits above the new limit. The stimulus changes configuration only when no pixel is in flight, and applies a fresh reset whenever seeds or depth change during reseed mode.

// File: rtl/pdr_pkg.sv
package pdr_pkg;

  typedef enum logic [1:0] {
    DEPTH_6  = 2'd0,
    DEPTH_8  = 2'd1,
    DEPTH_10 = 2'd2,
    DEPTH_12 = 2'd3
  } depth_e;

  // number of kept bits; 0 means "keep everything"
  function automatic int keep_bits(input depth_e d);
    case (d)
      DEPTH_6:  return 6;
      DEPTH_8:  return 8;
      DEPTH_10: return 10;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/pdr_lane.sv
module pdr_lane #(
  parameter int PIX_W      = 12,
  parameter int LFSR_W     = 28,
  parameter int FC_W       = 4,
  parameter int TAP_ALT    = 3,
  parameter int TAP_COMMON = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              reload,
  input  logic              per_chan,
  input  logic              highpass,
  input  logic              dith_en,
  input  logic              trunc_eff,
  input  logic [PIX_W-1:0]  low_mask,
  input  logic [LFSR_W-1:0] seed,
  input  logic [FC_W-1:0]   fc,
  input  logic [PIX_W-1:0]  pix_in,
  output logic [PIX_W-1:0]  pix_out
);
  localparam int EXT = 3;
  localparam int SW  = PIX_W + EXT;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s,
                                                  input logic alt);
    logic fb;
    fb = s[LFSR_W-1] ^ (alt ? s[TAP_ALT-1] : s[TAP_COMMON-1]);
    return {s[LFSR_W-2:0], fb};
  endfunction

  function automatic logic [PIX_W-1:0] sat_add(input logic [PIX_W-1:0] a,
                                               input logic signed [SW-1:0] n);
    logic signed [SW-1:0] t;
    t = $signed({{EXT{1'b0}}, a}) + n;
    if (t[SW-1])                         return '0;
    else if (t[SW-2:PIX_W] != '0)        return '1;
    else                                 return t[PIX_W-1:0];
  endfunction

  logic [LFSR_W-1:0]    state_q, cur_state;
  logic [PIX_W-1:0]     prev_q, prev_eff, slice, dithered;
  logic signed [SW-1:0] diff, noise;

  always_comb begin
    cur_state = reload ? (seed ^ LFSR_W'(fc)) : state_q;
    slice     = cur_state[PIX_W-1:0] & low_mask;
    prev_eff  = reload ? '0 : prev_q;
    diff      = $signed({{EXT{1'b0}}, slice}) - $signed({{EXT{1'b0}}, prev_eff});
    noise     = highpass ? (diff >>> 1) : $signed({{EXT{1'b0}}, slice});
    dithered  = sat_add(pix_in, noise) & ~low_mask;
    if (dith_en)        pix_out = dithered;
    else if (trunc_eff) pix_out = pix_in & ~low_mask;
    else                pix_out = pix_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= seed;
      prev_q  <= '0;
    end else if (adv) begin
      state_q <= lfsr_step(cur_state, per_chan);
      prev_q  <= slice;
    end
  end

  // R11: register only moves on a valid pixel
  assert_lfsr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state_q));

  // R5: a nonzero register never collapses to zero by stepping
  assert_lfsr_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != '0 && !reload) |=> state_q != '0);

  // R9: with dither off the noise path must not touch the pixel
  assert_no_dither_leak_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dith_en && !trunc_eff) |-> pix_out == pix_in);

endmodule

// File: rtl/pix_depth_reducer.sv
module pix_depth_reducer #(
  parameter int PIX_W      = 12,
  parameter int LFSR_W     = 28,
  parameter int FC_W       = 4,
  parameter int TAP_COMMON = 3,
  parameter int TAP_R      = 3,
  parameter int TAP_G      = 9,
  parameter int TAP_B      = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_trunc_en,
  input  logic              cfg_dither_en,
  input  logic [1:0]        cfg_depth,
  input  logic              cfg_ycc422,
  input  logic              cfg_chan_taps,
  input  logic              cfg_frame_reseed,
  input  logic              cfg_highpass,
  input  logic [LFSR_W-1:0] cfg_seed_r,
  input  logic [LFSR_W-1:0] cfg_seed_g,
  input  logic [LFSR_W-1:0] cfg_seed_b,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eol,
  input  logic [PIX_W-1:0]  in_r,
  input  logic [PIX_W-1:0]  in_g,
  input  logic [PIX_W-1:0]  in_b,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eol,
  output logic [PIX_W-1:0]  out_r,
  output logic [PIX_W-1:0]  out_g,
  output logic [PIX_W-1:0]  out_b
);
  import pdr_pkg::*;

  localparam int NCH = 3;

  depth_e             dep;
  logic               trunc_eff, reload;
  logic [PIX_W-1:0]   low_mask;
  logic [FC_W-1:0]    fc_q, fc_lim;
  logic [LFSR_W-1:0]  seed_a [NCH];
  logic [PIX_W-1:0]   pin_a  [NCH];
  logic [PIX_W-1:0]   pout_a [NCH];

  function automatic logic [PIX_W-1:0] mask_for(input depth_e d);
    int k;
    k = keep_bits(d);
    if (k == 0) return '0;
    return PIX_W'((1 << (PIX_W - k)) - 1);
  endfunction

  always_comb begin
    dep       = depth_e'(cfg_depth);
    low_mask  = mask_for(dep);
    trunc_eff = cfg_trunc_en && (!cfg_ycc422 || dep == DEPTH_8 || dep == DEPTH_10);
    fc_lim    = (dep == DEPTH_6 || dep == DEPTH_8) ? '1 : FC_W'(3);
    reload    = in_valid && in_sof && cfg_frame_reseed;
    seed_a[0] = cfg_seed_r;
    seed_a[1] = cfg_seed_g;
    seed_a[2] = cfg_seed_b;
    pin_a[0]  = in_r;
    pin_a[1]  = in_g;
    pin_a[2]  = in_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      fc_q <= '0;
    else if (reload) fc_q <= (fc_q >= fc_lim) ? '0 : fc_q + 1'b1;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    pdr_lane #(
      .PIX_W     (PIX_W),
      .LFSR_W    (LFSR_W),
      .FC_W      (FC_W),
      .TAP_ALT   ((i == 0) ? TAP_R : (i == 1) ? TAP_G : TAP_B),
      .TAP_COMMON(TAP_COMMON)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (in_valid),
      .reload   (reload),
      .per_chan (cfg_chan_taps),
      .highpass (cfg_highpass),
      .dith_en  (cfg_dither_en),
      .trunc_eff(trunc_eff),
      .low_mask (low_mask),
      .seed     (seed_a[i]),
      .fc       (fc_q),
      .pix_in   (pin_a[i]),
      .pix_out  (pout_a[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_r     <= '0;
      out_g     <= '0;
      out_b     <= '0;
    end else begin
      out_valid <= in_valid;
      out_sof   <= in_valid && in_sof;
      out_eol   <= in_valid && in_eol;
      if (in_valid) begin
        out_r <= pout_a[0];
        out_g <= pout_a[1];
        out_b <= pout_a[2];
      end
    end
  end

  // R12: valid follows input one cycle later, pixel holds when idle
  assert_valid_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b)));

  // R1: dropped bits are zero whenever reduction applies
  assert_low_bits_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (cfg_dither_en || trunc_eff))
      |=> ((out_r | out_g | out_b) & $past(low_mask)) == '0);

  // R3: nothing enabled means identity
  assert_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_dither_en && !trunc_eff)
      |=> (out_r == $past(in_r) && out_g == $past(in_g) && out_b == $past(in_b)));

  // R8: frame counter returns to zero at its limit
  assert_fc_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && fc_q >= fc_lim) |=> fc_q == '0);

endmodule

// File: tb/pix_depth_reducer_bench.sv
module pix_depth_reducer_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        trunc_en = 0, dith_en = 0, ycc = 0, chan_taps = 0, reseed = 0, hp = 0;
  logic [1:0]  depth = 0;
  logic [27:0] seed [3];
  logic        in_valid = 0, in_sof = 0, in_eol = 0;
  logic [11:0] in_r = 0, in_g = 0, in_b = 0;
  logic        out_valid, out_sof, out_eol;
  logic [11:0] out_r, out_g, out_b;

  pix_depth_reducer u_pix_depth_reducer (
    .clk(clk), .rst_n(rst_n),
    .cfg_trunc_en(trunc_en), .cfg_dither_en(dith_en), .cfg_depth(depth),
    .cfg_ycc422(ycc), .cfg_chan_taps(chan_taps), .cfg_frame_reseed(reseed),
    .cfg_highpass(hp), .cfg_seed_r(seed[0]), .cfg_seed_g(seed[1]), .cfg_seed_b(seed[2]),
    .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
    .out_r(out_r), .out_g(out_g), .out_b(out_b));

  typedef struct {
    logic [11:0] r, g, b;
    logic        sof, eol;
    string       tag;
  } item_t;
  item_t q[$];

  int checks = 0, errors = 0;
  bit done = 0;

  // independent reference state
  logic [27:0] m_st [3];
  int          m_pv [3];
  int          m_fc;
  int          ktab [3] = '{3, 9, 13};

  function automatic int drop_of(logic [1:0] d);
    return (d == 0) ? 6 : (d == 1) ? 4 : (d == 2) ? 2 : 0;
  endfunction

  function automatic logic [11:0] model_chan(int c, logic [11:0] pin, logic rl);
    logic [27:0] cur;
    int msk, sl, p, nz, sum, tap;
    bit tr_ok;
    msk = (1 << drop_of(depth)) - 1;
    cur = rl ? (seed[c] ^ 28'(m_fc)) : m_st[c];
    sl  = int'(cur[11:0]) & msk;
    p   = rl ? 0 : m_pv[c];
    nz  = hp ? ((sl - p) >>> 1) : sl;
    tap = chan_taps ? ktab[c] : 3;
    m_st[c] = {cur[26:0], cur[27] ^ cur[tap-1]};
    m_pv[c] = sl;
    tr_ok = trunc_en && (!ycc || depth == 1 || depth == 2);
    if (dith_en) begin
      sum = int'(pin) + nz;
      if (sum < 0) sum = 0;
      if (sum > 4095) sum = 4095;
      return 12'(sum & ~msk);
    end
    if (tr_ok) return pin & ~12'(msk);
    return pin;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int c = 0; c < 3; c++) begin m_st[c] = seed[c]; m_pv[c] = 0; end
    m_fc  = 0;
    rst_n = 1'b1;
  endtask

  task automatic send(logic [11:0] r, logic [11:0] g, logic [11:0] b,
                      logic sof, logic eol, string tag);
    item_t it;
    logic rl;
    int lim;
    @(negedge clk);
    in_valid = 1; in_sof = sof; in_eol = eol; in_r = r; in_g = g; in_b = b;
    rl = reseed && sof;
    it.r = model_chan(0, r, rl);
    it.g = model_chan(1, g, rl);
    it.b = model_chan(2, b, rl);
    it.sof = sof; it.eol = eol; it.tag = tag;
    if (rl) begin
      lim = (depth <= 1) ? 15 : 3;
      m_fc = (m_fc >= lim) ? 0 : m_fc + 1;
    end
    q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eol = 0;
    end
  endtask

  task automatic drain();
    idle(1);
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) check(0, "R12 output without pending pixel", 1, 0);
      else begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (out_r !== it.r || out_g !== it.g || out_b !== it.b ||
            out_sof !== it.sof || out_eol !== it.eol) begin
          errors++;
          $display("FAIL %s: actual r=%h g=%h b=%h sof=%b eol=%b expected r=%h g=%h b=%h sof=%b eol=%b",
                   it.tag, out_r, out_g, out_b, out_sof, out_eol,
                   it.r, it.g, it.b, it.sof, it.eol);
        end
      end
    end
  end

  task automatic burst(int n, int base, string tag);
    for (int i = 0; i < n; i++)
      send(12'(base + i * 397), 12'(base * 3 + i * 1231), 12'(4095 - base - i * 211),
           i == 0, i == n - 1, tag);
  endtask

  initial begin
    seed[0] = 28'h9A3C1E7; seed[1] = 28'hC5F0F1B; seed[2] = 28'hE765432;

    // R12: reset state
    do_reset();
    check(out_valid == 0 && out_r == 0 && out_g == 0 && out_b == 0 && out_sof == 0,
          "R12 reset outputs", int'(out_r), 0);

    // R3: passthrough
    burst(6, 100, "R3 passthrough");
    drain();

    // R1, R2: truncation at all depth codes
    trunc_en = 1;
    for (int d = 0; d < 4; d++) begin
      depth = 2'(d);
      burst(4, 37 * d + 5, "R1 R2 truncation");
      drain();
    end

    // R4: 4:2:2 restricts truncation codes
    ycc = 1;
    for (int d = 0; d < 4; d++) begin
      depth = 2'(d);
      burst(3, 900 + d, "R4 ycc422 truncation rule");
      drain();
    end
    ycc = 0; trunc_en = 0;

    // R5, R9, R11: common-tap dither with gaps in valid
    dith_en = 1; depth = 0;
    do_reset();
    for (int i = 0; i < 10; i++) begin
      send(12'(i * 401 + 7), 12'(i * 113), 12'(2000 + i), i == 0, i == 9, "R5 R9 R11 dither with gaps");
      if (i % 3 == 1) idle(2);
    end
    // R12: pixel output holds across idle cycles
    idle(3);
    drain();
    begin
      logic [11:0] held;
      held = out_r;
      idle(2);
      check(out_valid == 0 && out_r == held, "R12 hold while idle", int'(out_r), int'(held));
    end

    // R6: per-channel taps, depth 8 and 10
    chan_taps = 1;
    for (int d = 1; d < 3; d++) begin
      depth = 2'(d);
      burst(12, 50 * d, "R6 per-channel taps");
      drain();
    end

    // R9: saturation at all-ones
    depth = 0;
    for (int i = 0; i < 6; i++) send(12'hFFF, 12'(4090 + i), 12'hFC0, 0, 0, "R9 saturation");
    drain();

    // R10: high-pass, including clamp at zero
    hp = 1;
    for (int d = 0; d < 3; d++) begin
      depth = 2'(d);
      for (int i = 0; i < 8; i++) send(12'(i), 12'(2048 + i), 12'(4095 - i), i == 0, 0, "R10 highpass");
      drain();
    end
    hp = 0;

    // R7: reseed off, start-of-frame must not reload
    reseed = 0; depth = 1;
    do_reset();
    for (int f = 0; f < 4; f++) burst(3, 10 * f, "R7 no reload on frame start");
    drain();

    // R8: per-frame reseed, depth 10 wraps after 3
    reseed = 1; depth = 2;
    do_reset();
    for (int f = 0; f < 7; f++) burst(3, 200 + f, "R8 reseed wrap at 3");
    drain();

    // R8: depth 6 wraps after 15, with high-pass reload of previous slice
    depth = 0; hp = 1;
    do_reset();
    for (int f = 0; f < 18; f++) burst(2, 300 + 5 * f, "R8 R10 reseed wrap at 15");
    drain();
    hp = 0;

    // R8: reseed with common taps and truncation also set
    chan_taps = 0; trunc_en = 1; depth = 1;
    do_reset();
    for (int f = 0; f < 5; f++) burst(4, 60 * f, "R8 reseed common taps");
    drain();

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule